// File: doc/BRIEF.md
# Four-Way Cache Tag Directory

This block holds the address side of a four-way set-associative cache with 128 sets of 16-byte lines. Each way keeps, for every set, a 22-bit tag, a valid flag and a written (dirty) flag. A lookup takes a 32-bit physical address and uses bits 10..4 to pick the set. It compares bits 31..10 against the four stored tags, so bit 10 is both the top index bit and the bottom tag bit. It returns hit or miss, the hitting way and that way's dirty state one clock later. A store that hits while write-back mode is selected marks the way dirty.

A fill writes a new tag into a victim way chosen outside the block and marks that way valid and clean. The three highest address bits are shadow bits. A fill stores them as zero, and a lookup treats them as zero, so the shadow copies of an address share one entry. If the victim was valid and dirty, the block reports its old tag for one cycle so that the line can be written back. Data storage, the memory bus and way replacement belong to other blocks.

Lookups arrive on a valid/ready handshake. The block drops ready while a fill is presented, because a fill wins the shared storage port, and it also drops ready during either reset. The lookup result and the write-back notice are single-cycle pulses that cannot be stalled, so their consumer must take them when they appear. Fills have no ready and are taken on every cycle outside reset. Power-on reset clears all valid and dirty flags. Manual reset only clears the block's output pulses and leaves the directory contents intact. No reset touches the tags.

Top module: `ctd_top`

## Requirements
- R1: The set index is address bits 10..4 (128 sets) and the compared tag is address bits 31..10 (22 bits). Addresses that differ only in bit 10 fall in different sets.
- R2: An accepted lookup (lk_valid and lk_ready high at a clock edge) gives res_valid high for exactly the following cycle. res_hit is high only if some way of that set is valid and holds a matching tag, and res_way gives that way as a binary number (0..3). On a miss, res_way and res_dirty are 0.
- R3: When more than one way of the set is valid and matches, res_way reports the lowest-numbered of them.
- R4: A fill stores the tag with address bits 31..29 forced to zero, sets the way valid and clears its dirty flag. A lookup ignores address bits 31..29, and a write-back notice always carries zeros in the top three tag bits (evict_tag[21:19]).
- R5: A lookup with lk_store=1 and lk_wb=1 that hits sets the dirty flag of the reported way, and res_dirty then reads 1. A store with lk_wb=0, or any load, leaves the dirty flags unchanged. res_dirty shows the flag as it stands after the access.
- R6: A fill whose victim way is valid and dirty raises evict_valid for exactly the next cycle, with evict_tag equal to the victim's stored tag. A fill of a clean or invalid victim leaves evict_valid low.
- R7: While fill_valid is high, lk_ready is low and any lookup presented in that cycle is not performed (no res_valid follows).
- R8: With por_n low, all valid and dirty flags are cleared and res_valid and evict_valid are low. After power-on reset every lookup misses, and no fill reports a write-back.
- R9: With man_rst_n low, res_valid and evict_valid are low, but the valid and dirty flags are kept: a line that hit and was dirty before the manual reset still hits with res_dirty=1 afterwards.
- R10: While either reset is asserted, lk_ready is low and fills are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| man_rst_n | input | 1 | Manual reset, active low, synchronous |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_addr | input | 32 | Lookup physical address |
| lk_store | input | 1 | Lookup is a store |
| lk_wb | input | 1 | Store uses write-back mode |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | 32 | Address of the line being filled |
| fill_way | input | 2 | Victim way for the fill |
| res_valid | output | 1 | Lookup result pulse |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 2 | Hitting way |
| res_dirty | output | 1 | Dirty flag of the hitting way after the access |
| evict_valid | output | 1 | Victim needs write-back |
| evict_tag | output | 22 | Stored tag of the dirty victim |

## Verification
A lookup accepted at one edge has its hit, way and dirty result on the outputs after the next edge. A fill's write-back notice appears in the same place, and lk_ready responds to fill_valid and the resets within the cycle. The bench drives each request on a falling edge and lets one rising edge pass. It samples the outputs on the following falling edge, when they must hold the result of that request, and it returns the inputs to idle before the next request. The expected values come from a reference directory in the bench, which is updated at the same point. The back-pressure check reads lk_ready before the edge, in the cycle where fill_valid is raised.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  localparam int ADDR_W   = 32;
  localparam int LINE_B   = 16;
  localparam int OFF_W    = $clog2(LINE_B);
  localparam int SETS     = 128;
  localparam int IDX_W    = $clog2(SETS);
  localparam int WAYS     = 4;
  localparam int WAY_W    = $clog2(WAYS);
  localparam int TAG_LSB  = OFF_W + IDX_W - 1;   // tag shares the top index bit
  localparam int TAG_W    = ADDR_W - TAG_LSB;
  localparam int SHADOW_W = 3;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [WAY_W-1:0] way_t;

  function automatic idx_t set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
    tag_t t;
    t = a[ADDR_W-1:TAG_LSB];
    t[TAG_W-1 -: SHADOW_W] = '0;
    return t;
  endfunction
endpackage

// File: rtl/ctd_way.sv
module ctd_way
  import ctd_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  idx_t acc_idx,
  input  tag_t cmp_tag,
  input  logic wr_en,
  input  tag_t wr_tag,
  input  logic dirty_set,
  output logic match,
  output logic rd_valid,
  output logic rd_dirty,
  output tag_t rd_tag
);
  tag_t            tag_mem [SETS];
  logic [SETS-1:0] vld_q;
  logic [SETS-1:0] drt_q;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[acc_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else if (wr_en) begin
      vld_q[acc_idx] <= 1'b1;
      drt_q[acc_idx] <= 1'b0;
    end else if (dirty_set) begin
      drt_q[acc_idx] <= 1'b1;
    end
  end

  assign rd_tag   = tag_mem[acc_idx];
  assign rd_valid = vld_q[acc_idx];
  assign rd_dirty = drt_q[acc_idx];
  assign match    = rd_valid && (rd_tag == cmp_tag);

  // a dirty line is always a valid line
  p_dirty_has_valid_r5: assert property (@(posedge clk) disable iff (!por_n)
    rd_dirty |-> rd_valid);

  // leaving power-on reset, every flag is clear
  p_por_clears_r8: assert property (@(posedge clk)
    $rose(por_n) |-> (vld_q == '0 && drt_q == '0));
endmodule

// File: rtl/ctd_pick.sv
module ctd_pick
  import ctd_pkg::*;
(
  input  logic            clk,
  input  logic            chk_en,
  input  logic [WAYS-1:0] req,
  output logic            any,
  output way_t            sel,
  output logic [WAYS-1:0] grant
);
  always_comb begin
    any   = 1'b0;
    sel   = '0;
    grant = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (req[w]) begin
        any   = 1'b1;
        sel   = way_t'(w);
        grant = '0;
        grant[w] = 1'b1;
      end
    end
  end

  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!chk_en)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/ctd_top.sv
module ctd_top
  import ctd_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              man_rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_store,
  input  logic              lk_wb,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [WAY_W-1:0]  fill_way,
  output logic              res_valid,
  output logic              res_hit,
  output logic [WAY_W-1:0]  res_way,
  output logic              res_dirty,
  output logic              evict_valid,
  output logic [TAG_W-1:0]  evict_tag
);
  logic in_rst, fill_go, lk_go, store_go;
  idx_t acc_idx;
  tag_t cmp_tag, new_tag;
  logic [WAYS-1:0] match, rd_valid, rd_dirty, grant, dset;
  tag_t            rd_tag [WAYS];
  logic            hit_any;
  way_t            hit_way;

  assign in_rst   = !por_n || !man_rst_n;
  assign fill_go  = fill_valid && !in_rst;
  assign lk_ready = !in_rst && !fill_valid;
  assign lk_go    = lk_valid && lk_ready;
  assign store_go = lk_go && lk_store && lk_wb;
  assign acc_idx  = fill_go ? set_of(fill_addr) : set_of(lk_addr);
  assign cmp_tag  = tag_of(lk_addr);
  assign new_tag  = tag_of(fill_addr);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign dset[w] = store_go && grant[w];
    ctd_way u_way (
      .clk      (clk),
      .por_n    (por_n),
      .acc_idx  (acc_idx),
      .cmp_tag  (cmp_tag),
      .wr_en    (fill_go && (fill_way == way_t'(w))),
      .wr_tag   (new_tag),
      .dirty_set(dset[w]),
      .match    (match[w]),
      .rd_valid (rd_valid[w]),
      .rd_dirty (rd_dirty[w]),
      .rd_tag   (rd_tag[w])
    );
  end

  ctd_pick u_pick (
    .clk   (clk),
    .chk_en(por_n),
    .req   (match),
    .any   (hit_any),
    .sel   (hit_way),
    .grant (grant)
  );

  always_ff @(posedge clk) begin
    if (in_rst) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_way     <= '0;
      res_dirty   <= 1'b0;
      evict_valid <= 1'b0;
      evict_tag   <= '0;
    end else begin
      res_valid   <= lk_go;
      evict_valid <= fill_go && rd_valid[fill_way] && rd_dirty[fill_way];
      if (lk_go) begin
        res_hit   <= hit_any;
        res_way   <= hit_any ? hit_way : '0;
        res_dirty <= hit_any && (rd_dirty[hit_way] || store_go);
      end
      if (fill_go) evict_tag <= rd_tag[fill_way];
    end
  end

  p_result_needs_request_r2: assert property (@(posedge clk) disable iff (in_rst)
    res_valid |-> $past(lk_valid));

  p_fill_blocks_lookup_r7: assert property (@(posedge clk) disable iff (in_rst)
    $past(fill_valid) |-> !res_valid);

  p_evict_shadow_zero_r4: assert property (@(posedge clk) disable iff (in_rst)
    evict_valid |-> (evict_tag[TAG_W-1 -: SHADOW_W] == '0));

  p_evict_after_fill_r6: assert property (@(posedge clk) disable iff (in_rst)
    evict_valid |-> $past(fill_valid));

  p_miss_way_zero_r2: assert property (@(posedge clk) disable iff (in_rst)
    (res_valid && !res_hit) |-> (res_way == '0 && !res_dirty));
endmodule

// File: tb/ctd_top_tb_top.sv
module ctd_top_tb_top;
  logic        clk = 1'b0;
  logic        por_n, man_rst_n;
  logic        lk_valid, lk_store, lk_wb, fill_valid;
  logic [31:0] lk_addr, fill_addr;
  logic [1:0]  fill_way;
  logic        lk_ready, res_valid, res_hit, res_dirty, evict_valid;
  logic [1:0]  res_way;
  logic [21:0] evict_tag;

  int checks = 0;
  int errors = 0;

  logic        mv [128][4];
  logic        md [128][4];
  logic [21:0] mt [128][4];

  always #4 clk = ~clk;

  ctd_top dut_i (
    .clk(clk), .por_n(por_n), .man_rst_n(man_rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_store(lk_store), .lk_wb(lk_wb),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
    .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
    .res_dirty(res_dirty), .evict_valid(evict_valid), .evict_tag(evict_tag)
  );

  function automatic int m_idx(input logic [31:0] a);
    return int'(a[10:4]);
  endfunction

  function automatic logic [21:0] m_tag(input logic [31:0] a);
    return {3'b000, a[28:10]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_store = 0; lk_wb = 0; lk_addr = '0;
    fill_valid = 0; fill_addr = '0; fill_way = '0;
  endtask

  task automatic model_por();
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++) begin
        mv[s][w] = 0; md[s][w] = 0;
      end
  endtask

  task automatic do_lookup(input logic [31:0] a, input logic st, input logic wb, input string req);
    int s; logic h; int way; logic d;
    s = m_idx(a); h = 0; way = 0; d = 0;
    for (int w = 3; w >= 0; w--)
      if (mv[s][w] && mt[s][w] == m_tag(a)) begin h = 1; way = w; end
    if (h) begin
      if (st && wb) md[s][way] = 1;
      d = md[s][way];
    end
    lk_valid = 1; lk_addr = a; lk_store = st; lk_wb = wb;
    @(posedge clk); @(negedge clk);
    idle();
    chk({req, " res_valid"}, 32'(res_valid), 1);
    chk({req, " res_hit"}, 32'(res_hit), 32'(h));
    chk({req, " res_way"}, 32'(res_way), 32'(way));
    chk({req, " res_dirty"}, 32'(res_dirty), 32'(d));
  endtask

  task automatic do_fill(input logic [31:0] a, input int way, input string req);
    int s; logic ev; logic [21:0] et;
    s = m_idx(a);
    ev = mv[s][way] && md[s][way];
    et = mt[s][way];
    mv[s][way] = 1; md[s][way] = 0; mt[s][way] = m_tag(a);
    fill_valid = 1; fill_addr = a; fill_way = 2'(way);
    @(posedge clk); @(negedge clk);
    idle();
    chk({req, " evict_valid"}, 32'(evict_valid), 32'(ev));
    if (ev) chk({req, " evict_tag"}, 32'(evict_tag), 32'(et));
    chk({req, " no result on fill"}, 32'(res_valid), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd20240611));
    idle();
    por_n = 0; man_rst_n = 1;
    model_por();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset res_valid", 32'(res_valid), 0);
    chk("R8 reset evict_valid", 32'(evict_valid), 0);
    chk("R10 ready low in reset", 32'(lk_ready), 0);
    // a fill during reset must be ignored
    fill_valid = 1; fill_addr = 32'h0000_1230; fill_way = 0;
    @(posedge clk); @(negedge clk);
    idle();
    por_n = 1;
    @(negedge clk);
    chk("R10 ready after reset", 32'(lk_ready), 1);

    a = 32'h0000_1230;
    do_lookup(a, 0, 0, "R8 miss after por and R10 fill ignored");
    do_fill(a, 2, "R4 fill");
    do_lookup(a, 0, 0, "R2 hit way2");
    do_lookup(a ^ 32'h0000_0400, 0, 0, "R1 bit10 other set");
    do_lookup(a | 32'hE000_0000, 0, 0, "R4 shadow bits ignored");
    do_fill(a | 32'hA000_0000, 1, "R4 fill with shadow bits");
    do_lookup(a, 0, 0, "R3 lowest way");
    do_lookup(a, 1, 0, "R5 store without wb");
    do_lookup(a, 0, 0, "R5 dirty unchanged");
    do_lookup(a, 1, 1, "R5 wb store sets dirty");
    do_lookup(a, 0, 0, "R5 dirty kept");
    b = 32'h0123_5230;
    do_fill(b, 1, "R6 dirty victim");
    @(negedge clk);
    chk("R6 evict one cycle", 32'(evict_valid), 0);
    do_fill(b ^ 32'h0010_0000, 2, "R6 clean victim");

    // R7: fill and lookup together
    fill_valid = 1; fill_addr = 32'h0000_2040; fill_way = 3;
    lk_valid = 1; lk_addr = b;
    #1;
    chk("R7 ready low with fill", 32'(lk_ready), 0);
    mv[m_idx(32'h0000_2040)][3] = 1; md[m_idx(32'h0000_2040)][3] = 0;
    mt[m_idx(32'h0000_2040)][3] = m_tag(32'h0000_2040);
    @(posedge clk); @(negedge clk);
    idle();
    chk("R7 lookup dropped", 32'(res_valid), 0);
    do_lookup(32'h0000_2040, 0, 0, "R7 fill done");

    // R9: manual reset keeps flags
    do_lookup(b, 1, 1, "R9 make dirty");
    lk_valid = 1; lk_addr = b;
    man_rst_n = 0;
    #1;
    chk("R10 ready low in manual reset", 32'(lk_ready), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 res_valid cleared", 32'(res_valid), 0);
    idle();
    man_rst_n = 1;
    @(negedge clk);
    do_lookup(b, 0, 0, "R9 still hit and dirty");

    // R8: power-on reset drops everything
    por_n = 0;
    @(posedge clk); @(negedge clk);
    por_n = 1; model_por();
    @(negedge clk);
    do_lookup(b, 0, 0, "R8 miss after second por");
    do_fill(b, 1, "R8 no writeback after por");

    // constrained random mix
    for (int i = 0; i < 800; i++) begin
      logic [31:0] r;
      r = {$urandom_range(7, 0) == 0 ? 3'b101 : 3'b000,
           17'(32'h00AB0 + $urandom_range(2, 0)),
           $urandom_range(1, 0) == 1 ? 1'b1 : 1'b0,
           1'b0, 3'($urandom_range(2, 0)) << 1, 4'($urandom_range(15, 0))};
      if ($urandom_range(3, 0) == 0)
        do_fill(r, int'($urandom_range(3, 0)), "R6 random fill");
      else
        do_lookup(r, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), "R2 R3 R5 random lookup");
    end

    finish_run();
  end
endmodule